// File: doc/BRIEF.md
# Configurable Flash Burst Read Sequencer

This block is the read engine on the device side of a parallel NOR-style memory. A 16-bit read configuration word decides how reads behave. With the mode bit set, the engine does simple page-style reads: the word at the presented address shows up one core clock later, and the engine keeps doing this for as long as it is selected. With the mode bit clear, the engine does synchronous bursts. The burst is timed by a bus clock that the core clock samples, and one of its two edges is chosen as the active edge. An address-valid strobe seen on an active edge starts a burst. The engine then waits for the programmed latency and after that hands out one word on each active edge. The word address advances either linearly or inside an aligned window. A WAIT output covers the latency period, and both its polarity and its release point can be programmed.

The configuration word is loaded by a configure command. The reserved fields are forced to zero. A command that carries a reserved latency or length code is dropped, and the previous setting stays in place. The word can be read back through a separate identifier space. The memory array is a fixed register-file model, computed from the address, so the data pattern is known. Deselecting the engine ends any access on the next core clock.

Top module: `fbs_burst_reader`

## Requirements
- R1: After reset the configuration word reads 0xF94F. Reading identifier-space offset 5 returns the configuration word. Every other identifier offset returns 0.
- R2: An accepted configure command stores its data word with bits 9, 7, 5 and 4 forced to 0.
- R3: A configure command is dropped, and the stored word is kept, if its latency field (bits 14:11) is 0 or 1, or if its length field (bits 2:0) is not one of 001, 010, 011 or 111.
- R4: When bit 15 = 1 (page mode) and the engine is selected, dvalid is 1 and dout shows the word for the presented address one core clock later. An array word at address a is {~a[7:0], a[7:0]}, with a zero-extended to 8 bits.
- R5: When bit 15 = 0, a burst begins on the active edge that sees addr_vld. Call that edge 0. The first data word is valid after edge L, where L is bits 14:11.
- R6: When bit 3 = 1, or when the length is continuous, each active edge after the first word moves the address up by one, modulo the array size.
- R7: When bit 3 = 0 and the length is finite, the address stays inside the aligned window of that length. Only the low bits count up, and they wrap back to the start of the window.
- R8: Length code 001 gives 4 words, 010 gives 8 and 011 gives 16. dvalid drops on the active edge after the last of these words. Code 111 keeps delivering words until the engine is deselected.
- R9: Bit 8 = 0 releases WAIT on the edge that brings the first word. Bit 8 = 1 releases it one active edge earlier. WAIT is active from edge 0 until its release.
- R10: Bit 10 = 0 makes WAIT active low and bit 10 = 1 makes it active high. When WAIT is inactive, wait_o holds the inactive level.
- R11: Bit 6 = 1 makes the rising bus_clk edge the active edge. Bit 6 = 0 makes the falling edge active.
- R12: A burst from the identifier space repeats the same word on every beat for the whole burst length.
- R13: When sel goes low, dvalid is 0 and WAIT is inactive after the next core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_clk | input | 1 | Burst clock, sampled by clk |
| sel | input | 1 | Engine selected |
| addr_vld | input | 1 | Start address valid, sampled on an active edge |
| addr | input | AW | Word address |
| id_space | input | 1 | Access targets the identifier space instead of the array |
| cfg_wr | input | 1 | Configure command strobe |
| cfg_wdata | input | 16 | Configure command data |
| dout | output | 16 | Read data |
| dvalid | output | 1 | Read data valid |
| wait_o | output | 1 | WAIT, polarity set by bit 10 |

## Verification
Three things are hard to reach from the ports. One is the window wrap: it needs a start address that is not aligned, together with a length short enough that the low bits roll over while the upper bits stay fixed. The bench therefore starts wrapped bursts in the middle of 4-, 8- and 16-word windows, and it runs a linear burst that crosses the top of the array. The other two are the early WAIT release at the smallest legal latency and the falling-edge variant. Both are reached by loading those configurations and then driving bus_clk from the bench's own edge model. This lets a scoreboard predict each beat and the WAIT level on every active edge.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  localparam int          CFG_W     = 16;
  localparam logic [15:0] CFG_RESET = 16'hF94F;
  // bits that hold state; bits 9, 7, 5, 4 are tied to zero
  localparam logic [15:0] CFG_KEEP  = 16'hFD4F;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} bst_e;

  // number of words for a length code, 0 meaning endless
  function automatic logic [4:0] burst_words(input logic [2:0] bl);
    case (bl)
      3'b001:  return 5'd4;
      3'b010:  return 5'd8;
      3'b011:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  // low-bit mask of the aligned window, 0 when no window applies
  function automatic logic [3:0] window_mask(input logic [2:0] bl);
    case (bl)
      3'b001:  return 4'h3;
      3'b010:  return 4'h7;
      3'b011:  return 4'hF;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic cfg_legal(input logic [15:0] w);
    logic lat_ok;
    logic len_ok;
    lat_ok = (w[14:11] > 4'd1);
    len_ok = (w[2:0] == 3'b001) || (w[2:0] == 3'b010) ||
             (w[2:0] == 3'b011) || (w[2:0] == 3'b111);
    return lat_ok && len_ok;
  endfunction

endpackage

// File: rtl/fbs_cfg_reg.sv
module fbs_cfg_reg
  import fbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  cfg_q
);

  logic wr_legal;
  logic wr_take;

  assign wr_legal = cfg_legal(wr_data);
  assign wr_take  = wr_en && wr_legal;

  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    if (CFG_KEEP[b]) begin : g_ff
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bit_q <= CFG_RESET[b];
        else if (wr_take) bit_q <= wr_data[b];
      end
      assign cfg_q[b] = bit_q;
    end else begin : g_tie
      assign cfg_q[b] = 1'b0;
    end
  end

  // R3: a command with a reserved code leaves the word untouched
  a_r3_reject_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> $stable(cfg_q));

  // R2: an accepted command lands with reserved bits cleared
  a_r2_accept_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (cfg_q == ($past(wr_data) & CFG_KEEP)));

endmodule

// File: rtl/fbs_edge_det.sv
module fbs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic rise_sel,
  output logic tick
);

  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bus_clk;
  end

  logic rose_w;
  logic fell_w;
  assign rose_w = bus_clk && !bclk_q;
  assign fell_w = !bus_clk && bclk_q;
  assign tick   = rise_sel ? rose_w : fell_w;

  // R11: an active edge leaves bus_clk at the level the selected edge ends on
  a_r11_tick_level: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (bus_clk == rise_sel));

endmodule

// File: rtl/fbs_burst_ctl.sv
module fbs_burst_ctl
  import fbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          tick,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          id_space,
  input  logic          page_mode,
  input  logic [3:0]    lat_code,
  input  logic          wait_early,
  input  logic          linear,
  input  logic [2:0]    len_code,
  output logic [AW-1:0] cur_addr,
  output logic          cur_id,
  output logic          dvalid,
  output logic          wait_act
);

  localparam int BEAT_W = 5;

  bst_e              st;
  logic [AW-1:0]     cur;
  logic              idq;
  logic [3:0]        cnt;
  logic [BEAT_W-1:0] beat;
  logic              dv;
  logic              wt;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic [3:0]    m,
                                              input logic          lin);
    logic [AW-1:0] inc;
    logic [AW-1:0] mk;
    inc = a + AW'(1);
    mk  = AW'(m);
    if (lin || (m == 4'h0)) return inc;
    return (a & ~mk) | (inc & mk);
  endfunction

  // named events for the checks below
  logic [BEAT_W-1:0] words;
  logic [AW-1:0]     wmask;
  logic              wrap_on;
  logic              lat_hit;
  logic              burst_done;
  logic              sync_go;
  logic              beat_adv;
  logic              early_rel;
  logic [AW-1:0]     next_addr;

  assign words      = burst_words(len_code);
  assign wmask      = AW'(window_mask(len_code));
  assign wrap_on    = !linear && (words != '0);
  assign lat_hit    = (cnt == lat_code);
  assign burst_done = (words != '0) && (beat == words);
  assign sync_go    = sel && !page_mode && tick;
  assign beat_adv   = sync_go && (st == ST_DATA) && !burst_done;
  assign early_rel  = wait_early && ((cnt + 4'd1) == lat_code);
  assign next_addr  = step_addr(cur, window_mask(len_code), linear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cur  <= '0;
      idq  <= 1'b0;
      cnt  <= '0;
      beat <= '0;
      dv   <= 1'b0;
      wt   <= 1'b0;
    end else if (!sel) begin
      st <= ST_IDLE;
      dv <= 1'b0;
      wt <= 1'b0;
    end else if (page_mode) begin
      st  <= ST_IDLE;
      cur <= addr;
      idq <= id_space;
      dv  <= 1'b1;
      wt  <= 1'b0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          dv <= 1'b0;
          wt <= 1'b0;
          if (addr_vld) begin
            cur <= addr;
            idq <= id_space;
            cnt <= 4'd1;
            wt  <= 1'b1;
            st  <= ST_LAT;
          end
        end
        ST_LAT: begin
          if (lat_hit) begin
            dv   <= 1'b1;
            wt   <= 1'b0;
            beat <= BEAT_W'(1);
            st   <= ST_DATA;
          end else begin
            cnt <= cnt + 4'd1;
            wt  <= !early_rel;
          end
        end
        ST_DATA: begin
          if (burst_done) begin
            dv <= 1'b0;
            st <= ST_IDLE;
          end else begin
            if (!idq) cur <= next_addr;
            beat <= beat + BEAT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cur_addr = cur;
  assign cur_id   = idq;
  assign dvalid   = dv;
  assign wait_act = wt;

  // R9: WAIT never overlaps valid data
  a_r9_wait_clear_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    dv |-> !wt);

  // R7: a wrapped beat keeps the upper address bits
  a_r7_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && wrap_on && !idq) |=> (((cur ^ $past(cur)) & ~$past(wmask)) == '0));

  // R6: a linear beat moves the address up by one
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && !wrap_on && !idq) |=> (cur == ($past(cur) + AW'(1))));

  // R8: the beat count never passes the programmed length
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && (words != '0)) |-> (beat <= words));

  // R12: identifier bursts hold their word address
  a_r12_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_adv && idq) |=> $stable(cur));

  // R13: deselect ends the access
  a_r13_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!dv && !wt && (st == ST_IDLE)));

endmodule

// File: rtl/fbs_burst_reader.sv
module fbs_burst_reader
  import fbs_pkg::*;
#(
  parameter int AW         = 6,
  parameter int ID_CFG_OFS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_clk,
  input  logic          sel,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          id_space,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   dout,
  output logic          dvalid,
  output logic          wait_o
);

  localparam logic [AW-1:0] ID_OFS = AW'(ID_CFG_OFS);

  logic [CFG_W-1:0] cfg_q;
  logic             tick;
  logic [AW-1:0]    cur_addr;
  logic             cur_id;
  logic             wait_act;

  function automatic logic [15:0] array_word(input logic [AW-1:0] a);
    logic [7:0] a8;
    a8 = 8'(a);
    return {~a8, a8};
  endfunction

  fbs_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg_q   (cfg_q)
  );

  fbs_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_clk  (bus_clk),
    .rise_sel (cfg_q[6]),
    .tick     (tick)
  );

  fbs_burst_ctl #(.AW(AW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .tick       (tick),
    .addr_vld   (addr_vld),
    .addr       (addr),
    .id_space   (id_space),
    .page_mode  (cfg_q[15]),
    .lat_code   (cfg_q[14:11]),
    .wait_early (cfg_q[8]),
    .linear     (cfg_q[3]),
    .len_code   (cfg_q[2:0]),
    .cur_addr   (cur_addr),
    .cur_id     (cur_id),
    .dvalid     (dvalid),
    .wait_act   (wait_act)
  );

  logic [15:0] id_word;
  assign id_word = (cur_addr == ID_OFS) ? cfg_q : 16'h0000;
  assign dout    = cur_id ? id_word : array_word(cur_addr);
  assign wait_o  = cfg_q[10] ? wait_act : !wait_act;

  // R10: while deselected, wait_o rests at the level opposite the polarity bit
  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && $stable(cfg_q)) |=> (wait_o == !cfg_q[10]));

endmodule

// File: tb/fbs_burst_reader_bench.sv
module fbs_burst_reader_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_clk = 1'b0;
  logic        sel = 1'b0;
  logic        addr_vld = 1'b0;
  logic [5:0]  addr = '0;
  logic        id_space = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] dout;
  logic        dvalid;
  logic        wait_o;

  always #(CLK_P/2) clk = ~clk;

  fbs_burst_reader u_fbs_burst_reader (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .sel(sel),
    .addr_vld(addr_vld), .addr(addr), .id_space(id_space),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .dout(dout), .dvalid(dvalid), .wait_o(wait_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bench model of the configuration word
  logic [15:0] rcr_m = 16'hF94F;

  function automatic logic [15:0] mk_cfg(input bit rm, input logic [3:0] lc, input bit wp,
                                         input bit wd, input bit ce, input bit bw, input logic [2:0] bl);
    return {rm, lc, wp, 1'b0, wd, 1'b0, ce, 2'b00, bw, bl};
  endfunction

  function automatic bit legal_m(input logic [15:0] w);
    return (w[14:11] >= 4'd2) && (w[2:0] inside {3'd1, 3'd2, 3'd3, 3'd7});
  endfunction

  function automatic int lat_m();   return int'(rcr_m[14:11]); endfunction
  function automatic bit early_m(); return rcr_m[8]; endfunction
  function automatic bit wpol_m();  return rcr_m[10]; endfunction
  function automatic bit lin_m();   return rcr_m[3]; endfunction
  function automatic int len_m();
    case (rcr_m[2:0]) 3'd1: return 4; 3'd2: return 8; 3'd3: return 16; default: return 0; endcase
  endfunction

  function automatic logic [15:0] arr_m(input logic [5:0] a);
    int v;
    v = int'(a);
    return 16'(((255 - v) << 8) + v);
  endfunction

  function automatic logic [15:0] id_m(input logic [5:0] a);
    return (a == 6'd5) ? rcr_m : 16'h0000;
  endfunction

  function automatic logic [5:0] nxt_m(input logic [5:0] a);
    int ln;
    int v;
    ln = len_m();
    v  = int'(a);
    if (lin_m() || ln == 0) return a + 6'd1;
    return 6'((v / ln) * ln + ((v % ln) + 1) % ln);
  endfunction

  logic rise_m;
  assign rise_m = rcr_m[6];

  // scoreboard
  logic [15:0] exp_q[$];
  bit burst_on = 0;
  bit cont_on = 0;
  int k = 0;
  logic prev_b = 1'b0;
  logic was_tick = 1'b0;

  always @(posedge clk) begin
    was_tick <= sel && (rise_m ? (bus_clk && !prev_b) : (!bus_clk && prev_b));
    prev_b   <= bus_clk;
  end

  always @(negedge clk) begin
    if (burst_on && was_tick) begin
      bit exp_dv;
      bit exp_wt;
      logic [15:0] w;
      exp_dv = (k >= lat_m()) && (cont_on || k < lat_m() + len_m());
      exp_wt = (k < lat_m()) && (!early_m() || (k + 1 < lat_m()));
      chk(dvalid == exp_dv, "R5 R8 dvalid on edge", 32'(dvalid), 32'(exp_dv));
      chk(wait_o == (wpol_m() ? exp_wt : !exp_wt), "R9 R10 wait level", 32'(wait_o), 32'(exp_wt));
      if (dvalid && exp_dv) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 extra beat", 32'(dout), 32'h0);
        end else begin
          w = exp_q.pop_front();
          chk(dout == w, "R6 R7 R12 beat data", 32'(dout), 32'(w));
        end
      end
      k++;
    end
  end

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (legal_m(w)) rcr_m = w & 16'hFD4F;
  endtask

  task automatic page_read(input logic [5:0] a, input bit idf, input logic [15:0] exp, input string req);
    @(negedge clk);
    sel = 1'b1;
    addr = a;
    id_space = idf;
    @(negedge clk);
    chk(dvalid == 1'b1, req, 32'(dvalid), 32'h1);
    chk(dout == exp, req, 32'(dout), 32'(exp));
  endtask

  task automatic run_burst(input logic [5:0] a, input bit idf, input int n_cont);
    int n;
    int ticks;
    logic [5:0] c;
    cont_on = (len_m() == 0);
    n = cont_on ? n_cont : len_m();
    c = a;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(idf ? id_m(a) : arr_m(c));
      c = nxt_m(c);
    end
    ticks = cont_on ? (lat_m() + n) : (lat_m() + n + 2);
    @(negedge clk);
    sel = 1'b0;
    @(negedge clk);
    sel = 1'b1;
    if (bus_clk != !rise_m) begin
      @(negedge clk);
      bus_clk = ~bus_clk;
    end
    @(negedge clk);
    addr = a;
    id_space = idf;
    addr_vld = 1'b1;
    k = 0;
    burst_on = 1;
    bus_clk = ~bus_clk;
    for (int t = 0; t < ticks; t++) begin
      if (t > 0) begin
        @(negedge clk);
        bus_clk = ~bus_clk;
      end
      @(negedge clk);
      addr_vld = 1'b0;
      bus_clk = ~bus_clk;
    end
    @(negedge clk);
    #1 burst_on = 0;
    chk(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'h0);
    exp_q.delete();
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state: deselected, WAIT inactive high for active-low polarity
    chk(dvalid == 1'b0, "R13 reset dvalid", 32'(dvalid), 32'h0);
    chk(wait_o == 1'b1, "R10 reset wait idle level", 32'(wait_o), 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 readback of reset value and other identifier offsets
    page_read(6'd5, 1'b1, 16'hF94F, "R1 reset readback");
    page_read(6'd2, 1'b1, 16'h0000, "R1 other offset");
    // R4 page reads of the array
    page_read(6'd0,  1'b0, arr_m(6'd0),  "R4 page read 0");
    page_read(6'd37, 1'b0, arr_m(6'd37), "R4 page read 37");
    page_read(6'd63, 1'b0, arr_m(6'd63), "R4 page read 63");

    // R2 reserved bits forced to zero
    write_cfg(16'hFFFF);
    page_read(6'd5, 1'b1, 16'hFD4F, "R2 reserved masked");
    // R3 reserved latency and length codes dropped
    write_cfg(16'h8807);
    page_read(6'd5, 1'b1, 16'hFD4F, "R3 latency 1 dropped");
    write_cfg(16'hFD4C);
    page_read(6'd5, 1'b1, 16'hFD4F, "R3 length 100 dropped");
    write_cfg(16'h8007);
    page_read(6'd5, 1'b1, 16'hFD4F, "R3 latency 0 dropped");
    @(negedge clk);
    sel = 1'b0;

    // R7 4-word wrap, latency 2, release with data, rising edge
    write_cfg(mk_cfg(1'b0, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1));
    run_burst(6'd6, 1'b0, 0);
    // R6 linear 8 words across the array top, latency 5, early release, active high
    write_cfg(mk_cfg(1'b0, 4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2));
    run_burst(6'd60, 1'b0, 0);
    // R11 falling edge, 16-word wrap, latency 3
    write_cfg(mk_cfg(1'b0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3));
    run_burst(6'd37, 1'b0, 0);
    // R9 smallest latency with early release, 8-word wrap
    write_cfg(mk_cfg(1'b0, 4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2));
    run_burst(6'd13, 1'b0, 0);
    // R8 continuous with latency 15
    write_cfg(mk_cfg(1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 1'b1, 3'd7));
    run_burst(6'd10, 1'b0, 20);
    // R12 identifier burst repeats the configuration word
    write_cfg(mk_cfg(1'b0, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2));
    run_burst(6'd5, 1'b1, 0);

    // R13 deselect in the middle of a continuous burst
    write_cfg(mk_cfg(1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 3'd7));
    @(negedge clk);
    sel = 1'b1;
    if (bus_clk != 1'b0) begin
      @(negedge clk);
      bus_clk = 1'b0;
    end
    @(negedge clk);
    addr = 6'd20;
    id_space = 1'b0;
    addr_vld = 1'b1;
    bus_clk = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      addr_vld = 1'b0;
      bus_clk = ~bus_clk;
      @(negedge clk);
      bus_clk = ~bus_clk;
    end
    chk(dvalid == 1'b1, "R13 burst running before deselect", 32'(dvalid), 32'h1);
    sel = 1'b0;
    @(negedge clk);
    chk(dvalid == 1'b0, "R13 dvalid after deselect", 32'(dvalid), 32'h0);
    chk(wait_o == 1'b0, "R13 wait inactive after deselect", 32'(wait_o), 32'h0);

    repeat (3) @(negedge clk);
    report();
  end

endmodule